// File: doc/BRIEF.md
# Address boundary write protection unit

This block holds the write-protection state of a serial nonvolatile word store. A frame parser upstream hands it one decoded command per frame: a 2-bit opcode, an address field, a one-cycle end-of-frame strobe, and the levels of two control pins. One pin (`pre_i`) steers the opcode either to the main memory or to the protection logic. The other (`pe_i`) gates every programming action. The unit keeps a boundary address, a cleared flag and a one-time lock. It decides in the strobe cycle whether a memory write or a write-all may proceed. On a protection read it loads the boundary into a shifter that presents it one bit at a time, most significant bit first.

Changes to the protection state are two-step. An arming frame must come directly before the clear, load or lock frame. Any other frame in between withdraws the arming. Once the lock is set, only the power-on reset `rst_ni` removes it.

Top module: `wp_boundary_guard`

## Requirements
- R1: After `rst_ni` the unit is cleared, unlocked and not armed. The boundary reads back as 111111, and a memory write to any address is granted.
- R2: The 2-bit opcode field is decoded as follows, with `pre_i` choosing the target. With `pre_i` low, opcode 01 is a memory write. With `pre_i` high, opcode 01 is a protection load and never produces a grant.
- R3: While `pe_i` is low, no grant is given and no protection change takes place. A protection read still works.
- R4: A protection clear, load or lock takes effect only if the frame directly before it was the arming frame. The arming frame has `pre_i` high, `pe_i` high, opcode 00 and address bits [5:4] equal to 11. Any other frame disarms the unit, including an arming pattern sent with `pe_i` low.
- R5: A protection load (opcode 01, `pre_i` high) stores the address as the boundary and leaves the cleared state. Afterwards, memory writes at or above the boundary are refused and writes below it are granted.
- R6: A protection clear (opcode 11, `pre_i` high, address 111111) returns the unit to the cleared state, and the boundary reads 111111. The same opcode with any other address changes nothing.
- R7: A protection lock (opcode 00, `pre_i` high, address 000000) is permanent. After it, clear, load and lock are refused until `rst_ni`.
- R8: A write-all has `pre_i` low, opcode 00 and address bits [5:4] equal to 01. It is granted only in the cleared state with `pe_i` high.
- R9: A protection read (opcode 10, `pre_i` high, any address) loads the boundary into the shifter. `rd_bit_o` shows the MSB in the next cycle, and each cycle with `rd_shift_i` high advances by one bit. If the load and the shift fall in the same cycle, the load wins.
- R10: `wr_grant_o` is combinational in the strobe cycle and stays low whenever `frame_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| frame_i | input | 1 | End-of-frame strobe, one cycle per command |
| pre_i | input | 1 | High: opcode targets the protection logic |
| pe_i | input | 1 | High: programming permitted |
| opcode_i | input | 2 | Command opcode |
| addr_i | input | 6 | Address field of the frame |
| rd_shift_i | input | 1 | Advance the read shifter by one bit |
| wr_grant_o | output | 1 | Memory write or write-all permitted (strobe cycle) |
| rd_bit_o | output | 1 | Current bit of the boundary readout |

## Verification
Two functions can fall in the same cycle.

The first pair is the shifter load from a protection read and a shift pulse on `rd_shift_i`. The bench drives both in one cycle and expects the first bit observed afterwards to be the boundary MSB, not a shifted value.

The second pair is a boundary update and the grant decision of the very next frame. Each protection load in the vector table is followed directly by writes on both sides of the new boundary. Their grants are judged against the new value, never the old one.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [1:0] OP_EXT = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_ER  = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;

  typedef enum logic [3:0] {
    CMD_MEM_RD,
    CMD_MEM_WR,
    CMD_MEM_WRALL,
    CMD_MEM_OTHER,
    CMD_PR_EN,
    CMD_PR_CLR,
    CMD_PR_WR,
    CMD_PR_DIS,
    CMD_PR_RD,
    CMD_PR_OTHER
  } cmd_e;
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          pre_i,
  input  logic [1:0]    opcode_i,
  input  logic [AW-1:0] addr_i,
  output cmd_e          cmd_o
);
  logic [1:0] ext;
  assign ext = addr_i[AW-1 -: 2];

  always_comb begin
    cmd_o = CMD_MEM_OTHER;
    if (!pre_i) begin
      unique case (opcode_i)
        OP_RD:   cmd_o = CMD_MEM_RD;
        OP_WR:   cmd_o = CMD_MEM_WR;
        OP_EXT:  cmd_o = (ext == EXT_WRAL) ? CMD_MEM_WRALL : CMD_MEM_OTHER;
        default: cmd_o = CMD_MEM_OTHER;
      endcase
    end else begin
      unique case (opcode_i)
        OP_EXT: begin
          if (ext == EXT_EN)       cmd_o = CMD_PR_EN;
          else if (addr_i == '0)   cmd_o = CMD_PR_DIS;
          else                     cmd_o = CMD_PR_OTHER;
        end
        OP_WR:   cmd_o = CMD_PR_WR;
        OP_RD:   cmd_o = CMD_PR_RD;
        default: cmd_o = (addr_i == '1) ? CMD_PR_CLR : CMD_PR_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          pe_i,
  input  cmd_e          cmd_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bnd_o,
  output logic          cleared_o,
  output logic          locked_o
);
  logic          armed_q, locked_q, cleared_q;
  logic [AW-1:0] bnd_q;
  logic          upd_ok;

  // change window: armed by the directly preceding frame
  assign upd_ok = frame_i && armed_q && pe_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      locked_q  <= 1'b0;
      cleared_q <= 1'b1;
      bnd_q     <= '1;
    end else if (frame_i) begin
      armed_q <= (cmd_i == CMD_PR_EN) && pe_i;
      if (upd_ok) begin
        unique case (cmd_i)
          CMD_PR_CLR: begin
            bnd_q     <= '1;
            cleared_q <= 1'b1;
          end
          CMD_PR_WR: begin
            bnd_q     <= addr_i;
            cleared_q <= 1'b0;
          end
          CMD_PR_DIS: locked_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign bnd_o     = bnd_q;
  assign cleared_o = cleared_q;
  assign locked_o  = locked_q;

  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  p_lock_freezes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> ($stable(bnd_q) && $stable(cleared_q)));
  p_change_needs_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !armed_q) |=> ($stable(bnd_q) && $stable(cleared_q)));
  p_change_needs_pe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !pe_i) |=> ($stable(bnd_q) && $stable(locked_q)));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          pe_i,
  input  cmd_e          cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] bnd_i,
  input  logic          cleared_i,
  output logic          grant_o
);
  logic below, word_ok, all_ok;

  assign below   = addr_i < bnd_i;
  assign word_ok = (cmd_i == CMD_MEM_WR) && (cleared_i || below);
  assign all_ok  = (cmd_i == CMD_MEM_WRALL) && cleared_i;
  assign grant_o = frame_i && pe_i && (word_ok || all_ok);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |-> !grant_o);
  p_pe_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !pe_i) |-> !grant_o);
endmodule

// File: rtl/wp_rd_ser.sv
module wp_rd_ser #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [AW-1:0] bnd_i,
  output logic          bit_o
);
  logic [AW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= bnd_i;
    else if (shift_i) sr_q <= {sr_q[AW-2:0], 1'b0};
  end

  assign bit_o = sr_q[AW-1];

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sr_q == $past(bnd_i)));
  p_shift_msb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (bit_o == $past(sr_q[AW-2])));
endmodule

// File: rtl/wp_boundary_guard.sv
module wp_boundary_guard
  import wp_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          pre_i,
  input  logic          pe_i,
  input  logic [1:0]    opcode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_shift_i,
  output logic          wr_grant_o,
  output logic          rd_bit_o
);
  cmd_e          cmd;
  logic [AW-1:0] bnd;
  logic          cleared, locked;
  logic          rd_load;

  wp_decode #(.AW(AW)) u_dec (
    .pre_i(pre_i), .opcode_i(opcode_i), .addr_i(addr_i), .cmd_o(cmd)
  );

  wp_state #(.AW(AW)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .pe_i(pe_i),
    .cmd_i(cmd), .addr_i(addr_i),
    .bnd_o(bnd), .cleared_o(cleared), .locked_o(locked)
  );

  wp_guard #(.AW(AW)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .pe_i(pe_i),
    .cmd_i(cmd), .addr_i(addr_i), .bnd_i(bnd), .cleared_i(cleared),
    .grant_o(wr_grant_o)
  );

  assign rd_load = frame_i && (cmd == CMD_PR_RD);

  wp_rd_ser #(.AW(AW)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_load), .shift_i(rd_shift_i),
    .bnd_i(bnd), .bit_o(rd_bit_o)
  );

  p_pre_high_no_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && pre_i) |-> !wr_grant_o);
  p_wrall_needs_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !pre_i && opcode_i == 2'b00 && addr_i[AW-1 -: 2] == 2'b01 && wr_grant_o)
      |-> cleared);
  p_grant_below_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !pre_i && opcode_i == 2'b01 && wr_grant_o && !cleared) |-> (addr_i < bnd));
  p_locked_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(bnd));
endmodule

// File: tb/tb_wp_boundary_guard.sv
module tb_wp_boundary_guard;
  localparam int AW = 6;
  localparam int NV = 33;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_i = 1'b0, pre_i = 1'b0, pe_i = 1'b0, rd_shift_i = 1'b0;
  logic [1:0] opcode_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic wr_grant_o, rd_bit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wp_boundary_guard #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .pre_i(pre_i),
    .pe_i(pe_i), .opcode_i(opcode_i), .addr_i(addr_i),
    .rd_shift_i(rd_shift_i), .wr_grant_o(wr_grant_o), .rd_bit_o(rd_bit_o)
  );

  // {pre, pe, opcode, addr, expected grant}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b1,2'b01,6'd63,1'b1},  // R1 cleared after reset
    {1'b0,1'b0,2'b01,6'd5 ,1'b0},  // R3 pe low
    {1'b0,1'b1,2'b00,6'h10,1'b1},  // R8 write-all while cleared
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b1,1'b1,2'b01,6'd20,1'b0},  // R5 load 20
    {1'b0,1'b1,2'b01,6'd20,1'b0},  // R5 at boundary
    {1'b0,1'b1,2'b01,6'd19,1'b1},  // R5 below
    {1'b0,1'b1,2'b01,6'd63,1'b0},  // R5 top
    {1'b0,1'b1,2'b00,6'h10,1'b0},  // R8 not cleared
    {1'b1,1'b1,2'b01,6'd40,1'b0},  // R4 unarmed load
    {1'b0,1'b1,2'b01,6'd30,1'b0},  // R4 boundary still 20
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b0,1'b1,2'b10,6'd0 ,1'b0},  // memory read disarms
    {1'b1,1'b1,2'b11,6'h3f,1'b0},  // R4 clear refused
    {1'b0,1'b1,2'b01,6'd30,1'b0},  // R4
    {1'b1,1'b0,2'b00,6'h30,1'b0},  // arm pattern, pe low
    {1'b1,1'b1,2'b11,6'h3f,1'b0},  // R4 clear refused
    {1'b0,1'b1,2'b01,6'd25,1'b0},  // R4
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b1,1'b0,2'b11,6'h3f,1'b0},  // R3 clear with pe low
    {1'b0,1'b1,2'b01,6'd25,1'b0},  // R3
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b1,1'b1,2'b11,6'h3e,1'b0},  // R6 wrong address
    {1'b0,1'b1,2'b01,6'd25,1'b0},  // R6
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b1,1'b1,2'b11,6'h3f,1'b0},  // R6 clear
    {1'b0,1'b1,2'b01,6'd63,1'b1},  // R6
    {1'b0,1'b1,2'b00,6'h10,1'b1},  // R8
    {1'b1,1'b1,2'b01,6'd0 ,1'b0},  // R2 pre high, opcode 01
    {1'b0,1'b1,2'b01,6'd0 ,1'b1},  // R2 no effect
    {1'b1,1'b1,2'b00,6'h30,1'b0},  // arm
    {1'b1,1'b1,2'b01,6'd0 ,1'b0},  // R5 load 0
    {1'b0,1'b1,2'b01,6'd0 ,1'b0}   // R5 everything protected
  };

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic frame(input logic p, input logic e, input logic [1:0] op,
                       input logic [AW-1:0] a, output logic g);
    @(negedge clk);
    frame_i = 1'b1; pre_i = p; pe_i = e; opcode_i = op; addr_i = a;
    #1 g = wr_grant_o;
    @(posedge clk);
    #1 frame_i = 1'b0;
  endtask

  task automatic arm();
    logic g;
    frame(1'b1, 1'b1, 2'b00, 6'h30, g);
  endtask

  task automatic read_bnd(input string req, input logic [AW-1:0] exp);
    logic g;
    logic [AW-1:0] got;
    frame(1'b1, 1'b0, 2'b10, 6'h2a, g);
    got = '0;
    for (int i = 0; i < AW; i++) begin
      @(negedge clk);
      rd_shift_i = 1'b0;
      got = {got[AW-2:0], rd_bit_o};
      rd_shift_i = (i < AW-1);
    end
    @(negedge clk);
    rd_shift_i = 1'b0;
    check(req, got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic g;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R10: no strobe, no grant
    @(negedge clk);
    pre_i = 1'b0; pe_i = 1'b1; opcode_i = 2'b01; addr_i = '0;
    #1 check("R10", {5'b0, wr_grant_o}, 6'd0);

    read_bnd("R1 reset boundary", 6'h3f);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][10], VEC[v][9], VEC[v][8:7], VEC[v][6:1], g);
      check($sformatf("R2/R3/R4/R5/R6/R8 vec %0d", v), {5'b0, g}, {5'b0, VEC[v][0]});
    end

    // R9 readback, pe low, address ignored
    arm(); frame(1'b1, 1'b1, 2'b01, 6'd45, g);
    read_bnd("R9 readback", 6'd45);
    read_bnd("R3 read with pe low", 6'd45);

    // R9 load and shift in the same cycle
    @(negedge clk);
    frame_i = 1'b1; pre_i = 1'b1; pe_i = 1'b1; opcode_i = 2'b10; addr_i = '0;
    rd_shift_i = 1'b1;
    @(posedge clk);
    #1 frame_i = 1'b0; rd_shift_i = 1'b0;
    @(negedge clk);
    check("R9 load wins msb", {5'b0, rd_bit_o}, 6'd1);
    rd_shift_i = 1'b1;
    @(negedge clk);
    rd_shift_i = 1'b0;
    check("R9 second bit", {5'b0, rd_bit_o}, 6'd0);

    // R7 lock
    arm(); frame(1'b1, 1'b1, 2'b00, 6'd0, g);
    arm(); frame(1'b1, 1'b1, 2'b11, 6'h3f, g);
    frame(1'b0, 1'b1, 2'b01, 6'd50, g);
    check("R7 clear refused", {5'b0, g}, 6'd0);
    frame(1'b0, 1'b1, 2'b01, 6'd44, g);
    check("R7 below still granted", {5'b0, g}, 6'd1);
    arm(); frame(1'b1, 1'b1, 2'b01, 6'd10, g);
    read_bnd("R7 load refused", 6'd45);
    arm(); frame(1'b1, 1'b1, 2'b00, 6'd0, g);
    frame(1'b0, 1'b1, 2'b00, 6'h10, g);
    check("R7 write-all still blocked", {5'b0, g}, 6'd0);

    // R1 power-on reset clears the lock
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    read_bnd("R1 boundary after reset", 6'h3f);
    frame(1'b0, 1'b1, 2'b01, 6'd63, g);
    check("R1 write after reset", {5'b0, g}, 6'd1);
    arm(); frame(1'b1, 1'b1, 2'b01, 6'd7, g);
    read_bnd("R7 unlocked after reset", 6'd7);
    frame(1'b0, 1'b1, 2'b01, 6'd6, g);
    check("R5 below 7", {5'b0, g}, 6'd1);
    frame(1'b0, 1'b1, 2'b01, 6'd7, g);
    check("R5 at 7", {5'b0, g}, 6'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule